// File: doc/BRIEF.md
# Pseudo-Random Bit Sequence Generator with Lockup Recovery

This block produces a pseudo-random binary test pattern for measuring the bit error rate of a serial link. A shift register of ORDER stages feeds back the XOR of two tap stages. The feedback bit is both the next output bit and the bit shifted into the register. The order and the second tap are elaboration parameters. The default gives the 2^23 - 1 pattern, with taps at stages 23 and 18.

The output is a word of W bits, where W runs from 1 to 64. W = 1 is the plain serial form. Larger widths advance the sequence W bits per clock through an unrolled next-state network, so that a wide datapath at a modest clock rate can feed a fast serialiser. A register that holds all zeros would emit zeros for ever. The block detects that state and puts a one into the first stage before stepping, so the sequence starts again on its own.

Top module: `prbs_gen`

## Requirements
- R1: While reset is applied, valid_o is 0 and data_o is all zeros. The shift register holds the SEED parameter, which by default is all ones.
- R2: One serial step computes b = stage[ORDER] XOR stage[TAP] (default stages 23 and 18, stage 1 being the input end). It emits b and shifts it into stage 1, moving every other stage up by one.
- R3: Each enabled clock yields the next W serial bits in one word. The earliest bit is in bit W-1 (MSB) and the latest in bit 0. The register ends as it would after W serial steps. This holds for any W from 1 to 64.
- R4: When en_i is 0 at a clock edge, the register does not advance and data_o keeps its value.
- R5: valid_o is 1 in exactly the cycle after each edge at which en_i was 1, and is 0 after an edge at which en_i was 0.
- R6: If the register is all zeros at an enabled edge, stage 1 is treated as 1 before the W steps. The output leaves the stuck-at-zero condition and carries ones again.
- R7: With the default order and a nonzero seed, no run of identical output bits is longer than 23.
- R8: rst_n_i clears the block at once when it falls. After it rises, the block ignores en_i for two clock edges and first advances on the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| en_i | input | 1 | Advance the sequence by W bits at this edge |
| data_o | output | W | Pattern word, earliest bit in the MSB |
| valid_o | output | 1 | A new word is on data_o this cycle |

## Verification
The bench runs three instances side by side: the default 16-bit word, a 64-bit word, and a serial instance seeded with all zeros. Every word from each instance is compared with a bit-by-bit serial model. A wrong tap, a reversed bit order, or a chain that unrolls one step too few or too many breaks the match on the first word. The zero-seeded instance starts in the stuck state; without recovery it would emit only zeros and the check for ones would report it. Enable patterns with gaps, a reset in mid-run and an enable held high across reset release expose words that advance when idle, a valid strobe off by a cycle, and a synchroniser of the wrong depth.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  // Default pattern: 2^23 - 1, feedback from stages 23 and 18
  localparam int unsigned DEF_ORDER = 23;
  localparam int unsigned DEF_TAP   = 18;
  localparam int unsigned DEF_WIDTH = 16;
  localparam int unsigned MAX_WIDTH = 64;
  // Depth of the reset release synchroniser
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/prbs_rst_sync.sv
module prbs_rst_sync #(
  parameter int unsigned DEPTH = prbs_pkg::SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_sync_n_o
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_sync_n_o = chain_q[DEPTH-1];
endmodule

// File: rtl/prbs_zero_detect.sv
module prbs_zero_detect #(
  parameter int unsigned ORDER = prbs_pkg::DEF_ORDER
) (
  input  logic [ORDER-1:0] state_i,
  output logic             stuck_o,
  output logic [ORDER-1:0] start_o
);
  // An all-zero register means the output would run past ORDER zeros.
  localparam logic [ORDER-1:0] KICK = {{(ORDER-1){1'b0}}, 1'b1};

  always_comb begin
    stuck_o = ~|state_i;
    start_o = stuck_o ? KICK : state_i;
  end
endmodule

// File: rtl/prbs_unroll.sv
module prbs_unroll #(
  parameter int unsigned ORDER = prbs_pkg::DEF_ORDER,
  parameter int unsigned TAP   = prbs_pkg::DEF_TAP,
  parameter int unsigned W     = prbs_pkg::DEF_WIDTH
) (
  input  logic [ORDER-1:0] state_i,
  output logic [ORDER-1:0] state_o,
  output logic [W-1:0]     word_o
);
  localparam int unsigned HI = ORDER - 1;
  localparam int unsigned TI = TAP - 1;

  logic [ORDER-1:0] stage [0:W];
  logic [W-1:0]     fb;

  assign stage[0] = state_i;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_step
      assign fb[g] = stage[g][HI] ^ stage[g][TI];
      if (ORDER > 1) begin : g_shift
        assign stage[g+1] = {stage[g][ORDER-2:0], fb[g]};
      end else begin : g_single
        assign stage[g+1] = fb[g];
      end
      // earliest bit lands in the MSB
      assign word_o[W-1-g] = fb[g];
    end
  endgenerate

  assign state_o = stage[W];
endmodule

// File: rtl/prbs_core.sv
module prbs_core #(
  parameter int unsigned     ORDER = prbs_pkg::DEF_ORDER,
  parameter int unsigned     TAP   = prbs_pkg::DEF_TAP,
  parameter int unsigned     W     = prbs_pkg::DEF_WIDTH,
  parameter logic [ORDER-1:0] SEED = {ORDER{1'b1}}
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             en_i,
  output logic [ORDER-1:0] state_o,
  output logic [W-1:0]     data_o,
  output logic             valid_o
);
  logic [ORDER-1:0] state_q, state_d;
  logic [W-1:0]     data_q, data_d;
  logic             valid_q, valid_d;
  logic             stuck;
  logic [ORDER-1:0] start;
  logic [ORDER-1:0] adv_state;
  logic [W-1:0]     adv_word;

  prbs_zero_detect #(.ORDER(ORDER)) zdet_i (
    .state_i (state_q),
    .stuck_o (stuck),
    .start_o (start)
  );

  prbs_unroll #(.ORDER(ORDER), .TAP(TAP), .W(W)) unroll_i (
    .state_i (start),
    .state_o (adv_state),
    .word_o  (adv_word)
  );

  // next-state process; the stuck flag only steers the start value
  always_comb begin
    state_d = state_q;
    data_d  = data_q;
    valid_d = 1'b0;
    if (en_i) begin
      state_d = adv_state;
      data_d  = adv_word;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= SEED;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign state_o = state_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;

  logic unused_stuck;
  assign unused_stuck = stuck;
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen #(
  parameter int unsigned      W     = prbs_pkg::DEF_WIDTH,
  parameter int unsigned      ORDER = prbs_pkg::DEF_ORDER,
  parameter int unsigned      TAP   = prbs_pkg::DEF_TAP,
  parameter logic [ORDER-1:0] SEED  = {ORDER{1'b1}}
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         en_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);
  logic             rst_sync_n;
  logic [ORDER-1:0] state_q;

  prbs_rst_sync #(.DEPTH(prbs_pkg::SYNC_DEPTH)) rsync_i (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .rst_sync_n_o (rst_sync_n)
  );

  prbs_core #(.ORDER(ORDER), .TAP(TAP), .W(W), .SEED(SEED)) core_i (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .en_i    (en_i),
    .state_o (state_q),
    .data_o  (data_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/prbs_gen_chk.sv
module prbs_gen_chk #(
  parameter int unsigned W     = prbs_pkg::DEF_WIDTH,
  parameter int unsigned ORDER = prbs_pkg::DEF_ORDER
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             en_i,
  input logic             valid_i,
  input logic [W-1:0]     data_i,
  input logic [ORDER-1:0] state_i
);
  // R5
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    en_i |=> valid_i);

  // R5
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !en_i |=> !valid_i);

  // R4
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !en_i |=> $stable(data_i) && $stable(state_i));

  // R6
  state_live_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    valid_i |-> (state_i != '0));
endmodule

bind prbs_gen prbs_gen_chk #(.W(W), .ORDER(ORDER)) chk_i (
  .clk_i   (clk_i),
  .rst_n_i (rst_sync_n),
  .en_i    (en_i),
  .valid_i (valid_o),
  .data_i  (data_o),
  .state_i (state_q)
);

// File: tb/prbs_gen_tb_top.sv
`timescale 1ns/1ps
module prbs_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] d0; logic v0;
  logic [0:0]  d1; logic v1;
  logic [63:0] d2; logic v2;

  prbs_gen dut_i (.clk_i(clk), .rst_n_i(rst_n), .en_i(en), .data_o(d0), .valid_o(v0));
  prbs_gen #(.W(1), .SEED(23'd0)) ser_i (.clk_i(clk), .rst_n_i(rst_n), .en_i(en), .data_o(d1), .valid_o(v1));
  prbs_gen #(.W(64)) wide_i (.clk_i(clk), .rst_n_i(rst_n), .en_i(en), .data_o(d2), .valid_o(v2));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural model per instance
  int          mw   [3] = '{16, 1, 64};
  logic [22:0] mseed[3] = '{23'h7FFFFF, 23'h0, 23'h7FFFFF};
  logic [22:0] mst  [3];
  logic [63:0] mdat [3];
  bit          mval [3];
  int          mcnt;
  int          run_len = 0;
  logic        run_bit = 1'b0;
  int          max_run = 0;
  int          ser_ones = 0;

  function automatic logic [63:0] gen_word(inout logic [22:0] st, input int w);
    logic [63:0] wd = '0;
    if (st == 23'd0) st = 23'd1;   // R6 kick into stage 1
    for (int k = 0; k < w; k++) begin
      logic b = st[22] ^ st[17];    // R2 stages 23 and 18
      st = {st[21:0], b};
      wd = {wd[62:0], b};            // R3 earliest ends in MSB
    end
    return wd;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      mst[i] = mseed[i]; mdat[i] = '0; mval[i] = 1'b0;
    end
    mcnt = 0;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [63:0] a [3];
    bit          av[3];
    a[0] = {48'd0, d0}; a[1] = {63'd0, d1}; a[2] = d2;
    av[0] = v0; av[1] = v1; av[2] = v2;
    for (int i = 0; i < 3; i++) begin
      check(av[i] == mval[i], {tag, " valid R5"}, {63'd0, av[i]}, {63'd0, mval[i]});
      check(a[i] == mdat[i], {tag, " data R3"}, a[i], mdat[i]);
    end
  endtask

  // one clock: advance the model at the edge, compare at the falling edge
  task automatic cycle(input bit en_v);
    en = en_v;
    @(posedge clk);
    if (rst_n) begin
      if (mcnt < 2) begin               // R8 two ignored edges
        mcnt++;
        for (int i = 0; i < 3; i++) mval[i] = 1'b0;
      end else begin
        for (int i = 0; i < 3; i++) begin
          mval[i] = en_v;
          if (en_v) mdat[i] = gen_word(mst[i], mw[i]);   // R4 hold otherwise
        end
      end
    end
    @(negedge clk);
    compare_all(en_v ? "step" : "idle");
    if (v0) begin                        // R7 run length on the default stream
      for (int k = 15; k >= 0; k--) begin
        if (d0[k] == run_bit) run_len++;
        else begin run_bit = d0[k]; run_len = 1; end
        if (run_len > max_run) max_run = run_len;
      end
    end
    if (v1 && d1[0]) ser_ones++;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #1;
    // R1 reset state at the ports
    check(v0 == 1'b0 && d0 == 16'd0, "R1 reset outputs", {47'd0, v0, d0}, 64'd0);
    check(d2 == 64'd0 && v2 == 1'b0, "R1 reset wide", d2, 64'd0);
  endtask

  initial begin
    model_reset();
    en = 1'b0;
    repeat (3) @(negedge clk);
    apply_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) cycle(1'b0);
    // R1 first word comes from the all-ones seed
    for (int c = 0; c < 300; c++) cycle(1'b1);
    // R4 gaps in enable
    for (int c = 0; c < 300; c++) cycle((c % 3) == 0);
    for (int c = 0; c < 300; c++) cycle(($urandom % 4) != 0);
    check(ser_ones > 0, "R6 recovery from zero seed", ser_ones, 64'd1);
    // R8 enable held high across reset release
    apply_reset();
    en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 2; c++) begin
      cycle(1'b1);
      check(v0 == 1'b0, "R8 edge ignored after release", {63'd0, v0}, 64'd0);
    end
    cycle(1'b1);
    check(v0 == 1'b1, "R8 first advancing edge", {63'd0, v0}, 64'd1);
    for (int c = 0; c < 2000; c++) cycle(c % 7 != 3);
    check(max_run <= 23, "R7 run length", max_run, 64'd23);
    check(max_run >= 10, "R7 long runs present", max_run, 64'd10);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule